// File: doc/BRIEF.md
# Streaming Packed Sorted-List Merger

This block joins two sorted key lists into one sorted list. Each list arrives as a stream of W-bit words through a valid/ready handshake. Every word holds K unsigned keys of W/K bits, and each list runs from its largest key to its smallest. The merged list leaves in the same packed, nonincreasing layout, also through a valid/ready handshake, and the final word is marked.

The block works one whole word at a time. It keeps one word of K keys. On each step it takes one word from the input whose leading key is larger, with ties going to input A. It merges that word with the kept word in a bitonic network, sends out the K largest keys and keeps the K smallest. The kept word is stored in ascending order, so that it joins the next descending input word as a bitonic sequence.

The first word of a list pair is loaded by merging it against an all-ones word, and nothing is emitted on that step. The last kept word is flushed by merging it against an all-zeros word. Both of these steps use the same network as the normal merge step. After the flush, the block is ready for the next pair of lists.

Top module: `packed_merge_stream`

## Requirements
- R1: After reset, out_valid is low. With no input valid, a_ready and b_ready are low.
- R2: Key field i (i = 0..K-1) sits at bits [W-1-i*(W/K) -: W/K] of a word. Field 0 is the leftmost field. Keys are unsigned, and within a list they do not increase from field 0 to field K-1 or from one word to the next.
- R3: For input lists of NA and NB words, the output is exactly the NA+NB words that result from sorting all input keys in nonincreasing order and packing them per R2.
- R4: Each cycle, at most one input word is accepted. While neither list has ended and both heads are valid, the word accepted is the one whose field-0 key is larger. Equal field-0 keys select input A.
- R5: Once an input's word with its last flag has been accepted, that input's ready stays low. The remaining words come only from the other input.
- R6: out_last is high on the final output word of a list pair and low on every other output word.
- R7: While out_valid is high and out_ready is low, out_valid stays high and out_data and out_last stay unchanged. No word is lost or repeated.
- R8: Keys may use the full field range, 0 through 2^(W/K)-1. No bit of a field is reserved.
- R9: After the final word of one list pair is taken, the next list pair is merged correctly without a reset.
- R10: Accepting the first word of a list pair produces no output word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| a_valid | input | 1 | Input A word valid |
| a_ready | output | 1 | Input A word accepted this cycle |
| a_data | input | W | Input A packed keys |
| a_last | input | 1 | Marks the final word of list A |
| b_valid | input | 1 | Input B word valid |
| b_ready | output | 1 | Input B word accepted this cycle |
| b_data | input | W | Input B packed keys |
| b_last | input | 1 | Marks the final word of list B |
| out_valid | output | 1 | Merged word valid |
| out_ready | input | 1 | Downstream accepts the merged word |
| out_data | output | W | Merged packed keys |
| out_last | output | 1 | Marks the final merged word |

## Verification
A kept word in the wrong orientation, or a bad network stage, shows up as an unsorted or wrong output word. This appears in the very next emitted word, because each output holds the top half of the current kept word and the fetched word. A wrong head choice shows up as an output word that does not match the sorted reference. It becomes visible either in the same output word or one word later, when a key larger than an already emitted key comes out. An end flag that is not cleared, or a lost prime step, changes the output word count or the placement of out_last on the following list pair.

// File: rtl/pkm_pkg.sv
package pkm_pkg;
  // Sequencer phase: PRIME loads the first word of a list pair, RUN merges and flushes.
  typedef enum logic {
    PKM_PRIME = 1'b0,
    PKM_RUN   = 1'b1
  } pkm_state_e;
endpackage

// File: rtl/pkm_head_pick.sv
module pkm_head_pick #(
  parameter int W = 64,
  parameter int K = 8,
  localparam int FW = W / K
) (
  input  logic          a_valid,
  input  logic          b_valid,
  input  logic [FW-1:0] a_key,
  input  logic [FW-1:0] b_key,
  input  logic          a_done,
  input  logic          b_done,
  output logic          pick_a,
  output logic          pick_b
);
  // Larger leading key wins; equality favours A.
  function automatic logic lead_a(input logic [FW-1:0] ka, input logic [FW-1:0] kb);
    return ka >= kb;
  endfunction

  always_comb begin
    pick_a = 1'b0;
    pick_b = 1'b0;
    if (a_done && b_done) begin
      pick_a = 1'b0;
    end else if (a_done) begin
      pick_b = b_valid;
    end else if (b_done) begin
      pick_a = a_valid;
    end else if (a_valid && b_valid) begin
      pick_a = lead_a(a_key, b_key);
      pick_b = !lead_a(a_key, b_key);
    end
  end
endmodule

// File: rtl/pkm_word_merge.sv
module pkm_word_merge #(
  parameter int W = 64,
  parameter int K = 8,
  localparam int FW = W / K
) (
  input  logic [W-1:0] held,     // ascending left to right
  input  logic [W-1:0] fetched,  // descending left to right
  output logic [W-1:0] hi,       // K largest, descending
  output logic [W-1:0] lo        // K smallest, ascending
);
  logic [FW-1:0] up [K];
  logic [FW-1:0] dn [K];

  always_comb begin
    logic [FW-1:0] t;
    logic [FW-1:0] fk;
    logic [FW-1:0] hk;
    t = '0;
    // Half-cleaner over the bitonic sequence fetched ++ held.
    for (int i = 0; i < K; i++) begin
      fk = fetched[W-1-i*FW -: FW];
      hk = held[W-1-i*FW -: FW];
      up[i] = (fk >= hk) ? fk : hk;
      dn[i] = (fk >= hk) ? hk : fk;
    end
    // Bitonic merge of each half; upper half descending, lower half ascending.
    for (int s = K / 2; s > 0; s = s / 2) begin
      for (int i = 0; i < K; i++) begin
        if ((i & s) == 0) begin
          if (up[i] < up[i+s]) begin
            t = up[i]; up[i] = up[i+s]; up[i+s] = t;
          end
          if (dn[i] > dn[i+s]) begin
            t = dn[i]; dn[i] = dn[i+s]; dn[i+s] = t;
          end
        end
      end
    end
    for (int i = 0; i < K; i++) begin
      hi[W-1-i*FW -: FW] = up[i];
      lo[W-1-i*FW -: FW] = dn[i];
    end
  end
endmodule

// File: rtl/packed_merge_stream.sv
module packed_merge_stream #(
  parameter int W = 64,
  parameter int K = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         a_valid,
  output logic         a_ready,
  input  logic [W-1:0] a_data,
  input  logic         a_last,
  input  logic         b_valid,
  output logic         b_ready,
  input  logic [W-1:0] b_data,
  input  logic         b_last,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data,
  output logic         out_last
);
  import pkm_pkg::*;
  localparam int FW = W / K;

  pkm_state_e   state_q;
  logic         a_done_q, b_done_q;
  logic [W-1:0] held_q;
  logic         out_valid_q, out_last_q;
  logic [W-1:0] out_data_q;

  // Named internal events (observed by the checker).
  logic         pick_a, pick_b;
  logic         is_prime, both_done, slot_free;
  logic         step_take, step_flush, step_emit;
  logic [W-1:0] fetched, held_in, mrg_hi, mrg_lo;

  pkm_head_pick #(.W(W), .K(K)) u_pick (
    .a_valid (a_valid),
    .b_valid (b_valid),
    .a_key   (a_data[W-1 -: FW]),
    .b_key   (b_data[W-1 -: FW]),
    .a_done  (a_done_q),
    .b_done  (b_done_q),
    .pick_a  (pick_a),
    .pick_b  (pick_b)
  );

  assign is_prime   = (state_q == PKM_PRIME);
  assign both_done  = a_done_q && b_done_q;
  assign slot_free  = !out_valid_q || out_ready;
  assign step_flush = !is_prime && both_done && slot_free;
  assign step_take  = (pick_a || pick_b) && (is_prime || (!both_done && slot_free));
  assign step_emit  = step_flush || (step_take && !is_prime);

  assign a_ready = step_take && pick_a;
  assign b_ready = step_take && pick_b;

  // Prime: merge against all-ones so the first word drops to the kept half.
  // Flush: merge against all-zeros so the kept word rises to the emitted half.
  assign held_in = is_prime ? '1 : held_q;
  assign fetched = step_flush ? '0 : (pick_a ? a_data : b_data);

  pkm_word_merge #(.W(W), .K(K)) u_merge (
    .held    (held_in),
    .fetched (fetched),
    .hi      (mrg_hi),
    .lo      (mrg_lo)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q     <= PKM_PRIME;
      a_done_q    <= 1'b0;
      b_done_q    <= 1'b0;
      held_q      <= '0;
      out_valid_q <= 1'b0;
      out_last_q  <= 1'b0;
      out_data_q  <= '0;
    end else begin
      if (step_emit) begin
        out_valid_q <= 1'b1;
        out_data_q  <= mrg_hi;
        out_last_q  <= step_flush;
      end else if (out_ready) begin
        out_valid_q <= 1'b0;
      end
      if (step_take) begin
        held_q  <= mrg_lo;
        state_q <= PKM_RUN;
        if (a_ready && a_last) a_done_q <= 1'b1;
        if (b_ready && b_last) b_done_q <= 1'b1;
      end
      if (step_flush) begin
        state_q  <= PKM_PRIME;
        a_done_q <= 1'b0;
        b_done_q <= 1'b0;
      end
    end
  end

  assign out_valid = out_valid_q;
  assign out_data  = out_data_q;
  assign out_last  = out_last_q;
endmodule

// File: rtl/pkm_checker.sv
module pkm_checker #(
  parameter int W = 64,
  parameter int K = 8,
  localparam int FW = W / K
) (
  input logic         clk,
  input logic         rst_n,
  input logic         a_valid,
  input logic         a_ready,
  input logic [W-1:0] a_data,
  input logic         b_valid,
  input logic         b_ready,
  input logic [W-1:0] b_data,
  input logic         out_valid,
  input logic         out_ready,
  input logic [W-1:0] out_data,
  input logic         out_last,
  input logic         a_done,
  input logic         b_done,
  input logic         step_emit
);
  function automatic logic desc_ok(input logic [W-1:0] w);
    logic ok;
    ok = 1'b1;
    for (int i = 0; i < K - 1; i++)
      if (w[W-1-i*FW -: FW] < w[W-1-(i+1)*FW -: FW]) ok = 1'b0;
    return ok;
  endfunction

  logic          prev_ok;
  logic [FW-1:0] prev_min;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_ok  <= 1'b0;
      prev_min <= '0;
    end else if (out_valid && out_ready) begin
      prev_ok  <= !out_last;
      prev_min <= out_data[FW-1:0];
    end
  end

  AST_ONE_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    !(a_valid && a_ready && b_valid && b_ready)); // R4
  AST_PICK_A: assert property (@(posedge clk) disable iff (!rst_n)
    (a_valid && a_ready && b_valid && !b_done) |-> (a_data[W-1 -: FW] >= b_data[W-1 -: FW])); // R4
  AST_PICK_B: assert property (@(posedge clk) disable iff (!rst_n)
    (b_valid && b_ready && a_valid && !a_done) |-> (b_data[W-1 -: FW] > a_data[W-1 -: FW])); // R4
  AST_ENDED_A: assert property (@(posedge clk) disable iff (!rst_n)
    a_done |-> !a_ready); // R5
  AST_ENDED_B: assert property (@(posedge clk) disable iff (!rst_n)
    b_done |-> !b_ready); // R5
  AST_WORD_SORTED: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> desc_ok(out_data)); // R3
  AST_CROSS_SORTED: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && prev_ok) |-> (out_data[W-1 -: FW] <= prev_min)); // R3
  AST_HOLD_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last))); // R7
  AST_NO_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !step_emit); // R7
endmodule

bind packed_merge_stream pkm_checker #(.W(W), .K(K)) i_pkm_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .a_valid   (a_valid),
  .a_ready   (a_ready),
  .a_data    (a_data),
  .b_valid   (b_valid),
  .b_ready   (b_ready),
  .b_data    (b_data),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data),
  .out_last  (out_last),
  .a_done    (a_done_q),
  .b_done    (b_done_q),
  .step_emit (step_emit)
);

// File: tb/test_packed_merge_stream.sv
module test_packed_merge_stream;
  localparam int CLK_PERIOD = 10;
  localparam int W = 64;
  localparam int K = 8;
  localparam int FW = W / K;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic a_valid = 0, a_last = 0, b_valid = 0, b_last = 0, out_ready = 0;
  logic [W-1:0] a_data = '0, b_data = '0;
  logic a_ready, b_ready, out_valid, out_last;
  logic [W-1:0] out_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  packed_merge_stream #(.W(W), .K(K)) i_packed_merge_stream (
    .clk(clk), .rst_n(rst_n),
    .a_valid(a_valid), .a_ready(a_ready), .a_data(a_data), .a_last(a_last),
    .b_valid(b_valid), .b_ready(b_ready), .b_data(b_data), .b_last(b_last),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_last(out_last)
  );

  int n_checks = 0;
  int n_fail = 0;
  logic [W-1:0] la [16];
  logic [W-1:0] lb [16];
  int na, nb, a_stall, b_stall, o_stall;
  logic [FW-1:0] keys [256];
  bit [31:0] seed = 32'h1234_5678;

  task automatic check(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [FW-1:0] next_key(input int mode);
    seed = seed * 32'd1103515245 + 32'd12345;
    if (mode == 1) return seed[20] ? {FW{1'b1}} : '0;
    return seed[23:16];
  endfunction

  // R2 layout: field i at bits [W-1-i*FW -: FW]; sorted descending.
  task automatic make_list(input bit to_b, input int n, input int mode);
    logic [FW-1:0] t [128];
    logic [FW-1:0] x;
    for (int i = 0; i < n*K; i++) t[i] = next_key(mode);
    for (int i = 0; i < n*K; i++)
      for (int j = 0; j < n*K-1-i; j++)
        if (t[j] < t[j+1]) begin x = t[j]; t[j] = t[j+1]; t[j+1] = x; end
    for (int w = 0; w < n; w++)
      for (int f = 0; f < K; f++)
        if (to_b) lb[w][W-1-f*FW -: FW] = t[w*K+f];
        else      la[w][W-1-f*FW -: FW] = t[w*K+f];
    if (to_b) nb = n; else na = n;
  endtask

  task automatic build_expect();
    int m;
    logic [FW-1:0] x;
    m = 0;
    for (int w = 0; w < na; w++) for (int f = 0; f < K; f++) begin keys[m] = la[w][W-1-f*FW -: FW]; m++; end
    for (int w = 0; w < nb; w++) for (int f = 0; f < K; f++) begin keys[m] = lb[w][W-1-f*FW -: FW]; m++; end
    for (int i = 0; i < m; i++)
      for (int j = 0; j < m-1-i; j++)
        if (keys[j] < keys[j+1]) begin x = keys[j]; keys[j] = keys[j+1]; keys[j+1] = x; end
  endtask

  function automatic logic [W-1:0] exp_word(input int j);
    logic [W-1:0] r;
    for (int f = 0; f < K; f++) r[W-1-f*FW -: FW] = keys[j*K+f];
    return r;
  endfunction

  task automatic drive_a();
    for (int i = 0; i < na; i++) begin
      @(negedge clk);
      if (a_stall > 0 && i % 2 == 1) begin
        a_valid = 0;
        repeat (a_stall) @(negedge clk);
      end
      a_valid = 1; a_data = la[i]; a_last = (i == na-1);
      #1;
      while (!a_ready) begin @(negedge clk); #1; end
      @(posedge clk);
    end
    @(negedge clk);
    a_valid = 0; a_last = 0;
  endtask

  task automatic drive_b();
    for (int i = 0; i < nb; i++) begin
      @(negedge clk);
      if (b_stall > 0 && i % 2 == 0) begin
        b_valid = 0;
        repeat (b_stall) @(negedge clk);
      end
      b_valid = 1; b_data = lb[i]; b_last = (i == nb-1);
      #1;
      while (!b_ready) begin @(negedge clk); #1; end
      @(posedge clk);
    end
    @(negedge clk);
    b_valid = 0; b_last = 0;
  endtask

  task automatic collect(input string tag);
    int got = 0;
    int c = 0;
    bit done = 0;
    bit holding = 0;
    logic [W-1:0] held_d = '0;
    while (!done) begin
      @(negedge clk);
      c++;
      out_ready = (o_stall == 0) || (c % (o_stall + 1) == 0);
      #1;
      if (holding) check(out_valid && out_data == held_d, {tag, " R7 hold"}, out_data, held_d);
      if (out_valid && out_ready) begin
        check(out_data == exp_word(got), {tag, " R3 word"}, out_data, exp_word(got));
        check(out_last == (got == na+nb-1), {tag, " R6 last"}, W'(out_last), W'(got == na+nb-1));
        got++;
        if (out_last || got >= na+nb) done = 1;
        holding = 0;
      end else if (out_valid) begin
        holding = 1; held_d = out_data;
      end else begin
        holding = 0;
      end
    end
    check(got == na+nb, {tag, " R6 count"}, W'(got), W'(na+nb));
    @(negedge clk);
    out_ready = 0;
  endtask

  task automatic run_merge(input string tag);
    build_expect();
    fork
      drive_a();
      drive_b();
      collect(tag);
    join
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; a_valid = 0; b_valid = 0; a_last = 0; b_last = 0; out_ready = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic t_reset();
    do_reset();
    #1;
    check(out_valid == 1'b0, "R1 out_valid", W'(out_valid), '0);
    check(!a_ready && !b_ready, "R1 ready idle", W'({a_ready, b_ready}), '0);
  endtask

  task automatic t_pick();
    do_reset();
    a_valid = 1; a_data = 64'h5000_0000_0000_0000; a_last = 0;
    b_valid = 1; b_data = 64'h50FF_FFFF_FFFF_FFFF; b_last = 0;
    #1;
    check(a_ready && !b_ready, "R4 tie to A", W'({a_ready, b_ready}), 64'h2);
    b_data = 64'h5100_0000_0000_0000;
    #1;
    check(!a_ready && b_ready, "R4 larger B", W'({a_ready, b_ready}), 64'h1);
    a_valid = 0; b_valid = 0;
    #1;
    check(!a_ready && !b_ready, "R4 wait both", W'({a_ready, b_ready}), '0);
  endtask

  task automatic t_first_silent();
    do_reset();
    a_valid = 1; a_data = 64'h9080_7060_5040_3020; a_last = 0;
    b_valid = 1; b_data = 64'h1010_1010_1010_1010; b_last = 0;
    out_ready = 1;
    @(posedge clk);
    @(negedge clk);
    a_valid = 0; b_valid = 0;
    #1;
    check(out_valid == 1'b0, "R10 prime silent", W'(out_valid), '0);
    do_reset();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL R3 watchdog actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    a_stall = 0; b_stall = 0; o_stall = 0;
    t_reset();
    t_pick();
    t_first_silent();
    make_list(0, 4, 0); make_list(1, 4, 0); run_merge("R3 4x4");
    a_stall = 1; b_stall = 2; o_stall = 2;
    make_list(0, 3, 0); make_list(1, 5, 0); run_merge("R3 3x5 stalls");
    a_stall = 0; b_stall = 0; o_stall = 0;
    make_list(0, 1, 0); make_list(1, 1, 0); run_merge("R6 1x1");
    o_stall = 1;
    make_list(0, 1, 0); make_list(1, 6, 0); run_merge("R5 1x6");
    make_list(0, 6, 0); make_list(1, 1, 0); run_merge("R5 6x1");
    o_stall = 3;
    make_list(0, 4, 1); make_list(1, 3, 1); run_merge("R8 extremes");
    o_stall = 0; b_stall = 1;
    make_list(0, 2, 0); make_list(1, 3, 0); run_merge("R9 pair one");
    make_list(0, 5, 0); make_list(1, 2, 0); run_merge("R9 pair two");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule